// File: doc/BRIEF.md
# Single-Input Transition Counter on a Gray Ring

This block counts the transitions of one slow input. The input must already be synchronized to the clock, and it is sampled once per cycle. The machine holds a single state register. That register walks a closed ring of positions whose codes form a reflected Gray sequence, so each step changes exactly one state bit.

Even positions mean the input is low and odd positions mean it is high. The state therefore also records the input level, and no separate edge-detection flop is needed. Two counts are decoded from the one state:

- the ring position, in binary, gives the number of edges of either polarity, modulo the ring length;
- the number of rising edges is half of that, rounded up, and it wraps at half the ring length.

With the default width there are eight positions, visited in the code order 000, 001, 011, 010, 110, 111, 101, 100. The all-edge count therefore wraps at 8 and the rising-edge count wraps at 4.

Top module: `edge_ring_counter`

## Requirements
- R1: While `rst_n` is low, the state returns to code 000 and both `edge_cnt` and `rise_cnt` read 0. The input is then taken to be low.
- R2: On a clock edge where `sig_in` equals the level of the current position (low at even positions, high at odd ones), the state does not change.
- R3: On a clock edge where `sig_in` differs from the level of the current position, the state advances exactly one position around the ring.
- R4: With the default width, the state codes are visited in the order 000, 001, 011, 010, 110, 111, 101, 100 and then back to 000. Each step flips exactly one state bit.
- R5: `edge_cnt` is the binary ring position. It rises by one for every rising or falling edge of `sig_in` and wraps from 7 to 0.
- R6: `rise_cnt` rises by one on each low-to-high edge of `sig_in` and wraps from 3 to 0. It holds its value across high-to-low edges.
- R7: The counts respond to a change of `sig_in` after the first rising clock edge that samples the new level, and not before.
- R8: An input held at one level for any number of cycles after an edge produces no further counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; asynchronous, and also applied at each clock edge while low |
| sig_in | input | 1 | Synchronized input whose transitions are counted |
| rise_cnt | output | RING_W-1 | Rising edges modulo 2^(RING_W-1) |
| edge_cnt | output | RING_W | All edges modulo 2^RING_W |

## Verification
The hardest condition to reach is the wrap of both counts at once. It needs a full lap of eight edges with alternating levels, and the stimulus must stay in phase with the ring's level parity. A directed lap of sixteen alternating edges forces the wrap twice.

Long holds between edges are also needed, to show that a steady level is never counted again. Random toggling at a low rate supplies these holds. A reset in the middle of the run, issued with the input high, checks the return to code 000 from an odd position.

// File: rtl/edge_ring_pkg.sv
package edge_ring_pkg;
  localparam int MAXW = 16;
  typedef logic [MAXW-1:0] wide_t;

  // Reflected Gray code to binary, for the low n bits.
  function automatic wide_t gray_to_bin(input wide_t g, input int n);
    wide_t b;
    logic acc;
    b = '0;
    acc = 1'b0;
    for (int i = MAXW - 1; i >= 0; i--) begin
      if (i < n) begin
        acc = acc ^ g[i];
        b[i] = acc;
      end
    end
    return b;
  endfunction

  // Binary to reflected Gray code; the bits above n must be zero.
  function automatic wide_t bin_to_gray(input wide_t b);
    return b ^ (b >> 1);
  endfunction

  // Bit mask covering the low n bits.
  function automatic wide_t low_mask(input int n);
    wide_t m;
    m = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Position one step further round a ring of 2^n positions.
  function automatic wide_t next_pos(input wide_t p, input int n);
    return (p + wide_t'(1)) & low_mask(n);
  endfunction

  // Rising edges seen so far: half the ring position, rounded up.
  function automatic wide_t rises_of_pos(input wide_t p, input int n);
    return next_pos(p, n) >> 1;
  endfunction
endpackage

// File: rtl/ring_event_detect.sv
module ring_event_detect #(
  parameter int RW = 3
) (
  input  logic [RW-1:0] pos,
  input  logic          sig_in,
  output logic          lvl_exp,
  output logic          adv,
  output logic          rise_ev,
  output logic          fall_ev
);
  always_comb begin
    lvl_exp = pos[0];
    adv     = sig_in ^ lvl_exp;
    rise_ev = adv & sig_in;
    fall_ev = adv & ~sig_in;
  end
endmodule

// File: rtl/gray_ring_state.sv
module gray_ring_state
  import edge_ring_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [RW-1:0] pos,
  output logic [RW-1:0] st
);
  wide_t nxt_w;
  logic [RW-1:0] st_nxt;

  always_comb begin
    nxt_w  = bin_to_gray(next_pos(wide_t'(pos), RW));
    st_nxt = adv ? nxt_w[RW-1:0] : st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/ring_count_decode.sv
module ring_count_decode
  import edge_ring_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic [RW-1:0] st,
  output logic [RW-1:0] pos,
  output logic [RW-2:0] rises
);
  wide_t pos_w;
  wide_t rise_w;

  always_comb begin
    pos_w  = gray_to_bin(wide_t'(st), RW);
    rise_w = rises_of_pos(pos_w, RW);
    pos    = pos_w[RW-1:0];
    rises  = rise_w[RW-2:0];
  end
endmodule

// File: rtl/edge_ring_counter.sv
module edge_ring_counter #(
  parameter int RING_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  output logic [RING_W-2:0] rise_cnt,
  output logic [RING_W-1:0] edge_cnt
);
  logic [RING_W-1:0] st;
  logic [RING_W-1:0] pos;
  logic [RING_W-2:0] rises;
  logic lvl_exp, adv, rise_ev, fall_ev;

  ring_count_decode #(.RW(RING_W)) u_dec (
    .st(st), .pos(pos), .rises(rises)
  );

  ring_event_detect #(.RW(RING_W)) u_evt (
    .pos(pos), .sig_in(sig_in), .lvl_exp(lvl_exp),
    .adv(adv), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  gray_ring_state #(.RW(RING_W)) u_state (
    .clk(clk), .rst_n(rst_n), .adv(adv), .pos(pos), .st(st)
  );

  assign edge_cnt = pos;
  assign rise_cnt = rises;
endmodule

// File: rtl/edge_ring_checker.sv
module edge_ring_checker #(
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sig_in,
  input logic [RW-1:0] st,
  input logic [RW-1:0] edge_cnt,
  input logic [RW-2:0] rise_cnt,
  input logic          lvl_exp,
  input logic          adv,
  input logic          rise_ev,
  input logic          fall_ev
);
  localparam int CW = RW - 1;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_in == lvl_exp) |=> $stable(st));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_in != lvl_exp) |=> (edge_cnt == RW'($past(edge_cnt) + 1'b1)));

  p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st ^ $past(st)) <= 1);

  p_rise_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> (rise_cnt == CW'($past(rise_cnt) + 1'b1)));

  p_fall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> $stable(rise_cnt));

  p_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && $stable(sig_in)) |=> $stable(edge_cnt));
endmodule

bind edge_ring_counter edge_ring_checker #(.RW(RING_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .st(st),
  .edge_cnt(edge_cnt), .rise_cnt(rise_cnt), .lvl_exp(lvl_exp),
  .adv(adv), .rise_ev(rise_ev), .fall_ev(fall_ev)
);

// File: tb/edge_ring_counter_test.sv
module edge_ring_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic [1:0] rise_cnt;
  logic [2:0] edge_cnt;

  int checks = 0;
  int errors = 0;
  int m_edges = 0;
  int m_rises = 0;
  logic m_lvl = 1'b0;
  bit done = 1'b0;

  edge_ring_counter #(.RING_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .rise_cnt(rise_cnt), .edge_cnt(edge_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_edges();
    return m_edges % 8;
  endfunction

  function automatic int exp_rises();
    return m_rises % 4;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic compare_both(input string tag_e, input string tag_r);
    check(tag_e, int'(edge_cnt), exp_edges());
    check(tag_r, int'(rise_cnt), exp_rises());
  endtask

  // Check the previous sample's result, then drive a new level.
  task automatic tick(input logic nw, input string tag_e, input string tag_r);
    @(negedge clk);
    compare_both(tag_e, tag_r);
    sig_in = nw;
    if (nw != m_lvl) begin
      m_edges++;
      if (nw) m_rises++;
      m_lvl = nw;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 edge_cnt in reset", int'(edge_cnt), 0);
    check("R1 rise_cnt in reset", int'(rise_cnt), 0);
    sig_in = 1'b0;
    m_edges = 0;
    m_rises = 0;
    m_lvl = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    do_reset();

    // R2: low at an even position is held
    for (int i = 0; i < 5; i++) tick(1'b0, "R2 edge hold low", "R2 rise hold low");

    // R7: before the sampling edge nothing changes
    @(negedge clk);
    compare_both("R7 pre", "R7 pre");
    sig_in = 1'b1;
    m_edges++; m_rises++; m_lvl = 1'b1;
    #1;
    check("R7 edge_cnt before sample", int'(edge_cnt), 0);
    @(posedge clk);
    #1;
    check("R7 edge_cnt after sample", int'(edge_cnt), 1);
    check("R3 single advance", int'(edge_cnt), 1);
    check("R6 rise after first rising edge", int'(rise_cnt), 1);

    // R8: long high hold
    for (int i = 0; i < 12; i++) tick(1'b1, "R8 edge steady high", "R8 rise steady high");

    // R6: falling edge keeps rise count
    tick(1'b0, "R6 edge fall", "R6 rise fall");
    tick(1'b0, "R5 edge after fall", "R6 rise held after fall");

    // Full laps: alternate each cycle, wraps twice (R4, R5, R6)
    for (int i = 0; i < 16; i++)
      tick((m_lvl == 1'b0), "R4 R5 lap edge_cnt", "R6 lap rise_cnt wrap");
    tick(m_lvl, "R5 edge after laps", "R6 rise after laps");

    // Random slow toggling
    for (int i = 0; i < 3000; i++) begin
      logic nw;
      nw = (($urandom % 4) == 0) ? ~m_lvl : m_lvl;
      tick(nw, "R3 R5 random edge_cnt", "R6 random rise_cnt");
    end

    // Reset from an odd position with the input high (R1)
    if (m_lvl == 1'b0) tick(1'b1, "R5 pre-reset", "R6 pre-reset");
    tick(1'b1, "R5 pre-reset", "R6 pre-reset");
    do_reset();
    for (int i = 0; i < 4; i++) tick(1'b0, "R2 after reset", "R2 after reset");
    tick(1'b1, "R3 after reset", "R6 after reset");
    @(negedge clk);
    compare_both("R3 final", "R6 final");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule